// File: doc/BRIEF.md
# Buffered Synchronous Serial Master with Transfer Flags

This block is a byte-wide synchronous serial master whose data path and flags follow USART conventions. Software sees a small register window. One data address holds the transmit buffer on write and the receive buffer on read. A status address holds three flags: receive-complete, transmit-complete and data-register-empty. A control address holds three interrupt enables, a receiver enable and a transmitter enable.

A byte written to the transmit buffer moves into a shift register as soon as the shifter is free. It is then sent MSB first in clock mode 0: the serial clock idles low, the bit is driven while the clock is low and the input is sampled on the rising edge. Each half period of the serial clock lasts a fixed number of system clocks, set by a parameter. When a frame ends, the eight sampled input bits land in the receive buffer.

Each flag drives its own interrupt line, gated by the matching enable bit. Transmit-complete needs the shifter to be drained and the buffer to be empty. It is cleared by an interrupt acknowledge pulse or by writing a one to its bit. Turning the receiver off flushes the receive buffer. Turning the transmitter off lets frames that are already queued finish.

Top module: `usart_spi_master`

## Requirements
- R1: After reset, status reads 0x20 (only data-register-empty set), and sck_o, mosi_o and all three interrupt lines are low.
- R2: A write to address 0 with the transmitter enabled and the buffer empty is accepted. The byte enters the shift register one cycle later, which frees the buffer again. A write to address 0 while the buffer is full, or while the transmitter is disabled, is ignored: no extra frame is sent.
- R3: sck_o is low when idle. Each frame has 8 rising edges, with every half period lasting SCK_HALF system clocks. mosi_o carries the frame MSB first, changes only when sck_o falls, and is low when idle.
- R4: When a frame ends with the receiver enabled, the MISO bits sampled on the 8 rising edges (first bit as MSB) are placed in the receive buffer, and status bit 7 (receive-complete) is set.
- R5: Reading address 0 returns the receive buffer and clears receive-complete on the next cycle. A frame that ends in the same cycle keeps the flag set.
- R6: While the receiver is disabled (control bit 4 clear), receive-complete reads 0 and address 0 reads 0x00. Completed frames are not stored.
- R7: Status bit 6 (transmit-complete) sets one cycle after a frame ends, but only if no byte is waiting in the buffer. If a byte is waiting, the next frame starts and the flag does not set.
- R8: Transmit-complete clears when txc_ack_i is high, or when software writes a 1 to status bit 6. Writing 0 to that bit has no effect, and a setting event wins over a clear in the same cycle.
- R9: Status bit 5 (data-register-empty) reads 1 exactly when the transmit buffer is empty.
- R10: Status bits 4:0 and control bits 2:0 read 0, and writes to them are ignored. Address 3 reads 0x00. The control register reads back bits 7:3 as written.
- R11: irq_rxc_o, irq_txc_o and irq_dre_o each equal their status flag ANDed with control bit 7, 6 and 5 respectively.
- R12: Clearing the transmitter enable (control bit 3) does not stop a running frame or a buffered byte. Both are sent, and transmit-complete then sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effect at address 0) |
| reg_addr_i | input | 2 | Register address: 0 data, 1 status, 2 control |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from address |
| txc_ack_i | input | 1 | Transmit-complete interrupt acknowledge |
| irq_rxc_o | output | 1 | Receive-complete interrupt |
| irq_txc_o | output | 1 | Transmit-complete interrupt |
| irq_dre_o | output | 1 | Data-register-empty interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Register reads are combinational. They are checked one time unit after the falling edge on which the address is driven. A register write or flag event shows up in the status read on the cycle after the rising edge that captures it. A buffered byte enters the shifter one cycle after it is accepted. The serial clock first rises SCK_HALF cycles after that load. A frame lasts 16·SCK_HALF cycles, and the receive and transmit-complete flags follow one cycle after the last falling edge. A behavioural model in the bench advances on every rising edge with these latencies expressed as elapsed-cycle arithmetic. On every falling edge the bench compares sck_o, mosi_o, the interrupt lines and the read data against that model. Directed reads at fixed points add checks of flag values against literal expectations.

// File: rtl/usp_pkg.sv
package usp_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;
  localparam int unsigned CTRL_W = 5;

  // control bits, MSB first: 7..3 of the byte
  typedef struct packed {
    logic rxc_ie;
    logic txc_ie;
    logic dre_ie;
    logic rx_en;
    logic tx_en;
  } ctrl_t;
endpackage

// File: rtl/usp_clk_gen.sv
module usp_clk_gen #(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCK_HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q == LAST)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  p_tick_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (SCK_HALF > 1)) |=> !tick_o);
endmodule

// File: rtl/usp_shifter.sv
module usp_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              busy_q, done_q, sck_q, samp_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sck_q   <= 1'b0;
      samp_q  <= 1'b0;
      shreg_q <= '0;
      bit_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (load_i) begin
          busy_q  <= 1'b1;
          shreg_q <= data_i;
          sck_q   <= 1'b0;
          bit_q   <= '0;
        end
      end else if (tick_i) begin
        if (!sck_q) begin
          // rising edge: sample only, keep mosi steady
          sck_q  <= 1'b1;
          samp_q <= miso_i;
        end else begin
          sck_q   <= 1'b0;
          shreg_q <= {shreg_q[DATA_W-2:0], samp_q};
          bit_q   <= bit_q + 1'b1;
          if (bit_q == LAST_BIT) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = shreg_q;
  assign sck_o  = sck_q;
  assign mosi_o = busy_q & shreg_q[DATA_W-1];

  p_sck_idle_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  p_mosi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !sck_q) |=> $stable(shreg_q[DATA_W-1]));
endmodule

// File: rtl/usp_rx_buffer.sv
module usp_rx_buffer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_i,
  output logic              rxc_o,
  output logic [DATA_W-1:0] data_o
);
  logic              rxc_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxc_q  <= 1'b0;
      data_q <= '0;
    end else if (!en_i) begin
      rxc_q  <= 1'b0;
      data_q <= '0;
    end else if (wr_i) begin
      rxc_q  <= 1'b1;
      data_q <= data_i;
    end else if (rd_i) begin
      rxc_q  <= 1'b0;
    end
  end

  assign rxc_o  = rxc_q;
  assign data_o = data_q;

  p_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i) |=> rxc_o);
  p_read_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_i && !wr_i) |=> !rxc_o);
  p_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rxc_o && data_o == '0));
endmodule

// File: rtl/usart_spi_master.sv
module usart_spi_master
  import usp_pkg::*;
#(
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              txc_ack_i,
  output logic              irq_rxc_o,
  output logic              irq_txc_o,
  output logic              irq_dre_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int unsigned TXC_BIT = DATA_W - 2;

  ctrl_t             ctrl_q;
  logic              txb_full_q, txc_q;
  logic [DATA_W-1:0] txb_q;
  logic              sh_busy, sh_done, sh_tick, load;
  logic [DATA_W-1:0] sh_rx, rxb_data;
  logic              rxc;
  logic              wr_data, wr_stat, wr_ctrl, rd_data;

  assign wr_data = reg_we_i && (reg_addr_i == ADDR_DATA);
  assign wr_stat = reg_we_i && (reg_addr_i == ADDR_STAT);
  assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign rd_data = reg_re_i && (reg_addr_i == ADDR_DATA);
  assign load    = txb_full_q && !sh_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i[DATA_W-1 -: CTRL_W]);
  end

  // transmit buffer: drains regardless of tx_en, accepts only when enabled and empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txb_full_q <= 1'b0;
      txb_q      <= '0;
    end else if (load) begin
      txb_full_q <= 1'b0;
    end else if (wr_data && ctrl_q.tx_en && !txb_full_q) begin
      txb_full_q <= 1'b1;
      txb_q      <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    txc_q <= 1'b0;
    else if (sh_done && !txb_full_q)                txc_q <= 1'b1;
    else if (txc_ack_i || (wr_stat && reg_wdata_i[TXC_BIT])) txc_q <= 1'b0;
  end

  usp_clk_gen #(.SCK_HALF(SCK_HALF)) i_clk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (sh_busy),
    .tick_o (sh_tick)
  );

  usp_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (txb_q),
    .tick_i (sh_tick),
    .miso_i (miso_i),
    .busy_o (sh_busy),
    .done_o (sh_done),
    .rx_o   (sh_rx),
    .sck_o  (sck_o),
    .mosi_o (mosi_o)
  );

  usp_rx_buffer #(.DATA_W(DATA_W)) i_rx_buffer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q.rx_en),
    .wr_i   (sh_done),
    .data_i (sh_rx),
    .rd_i   (rd_data),
    .rxc_o  (rxc),
    .data_o (rxb_data)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_DATA: reg_rdata_o = rxb_data;
      ADDR_STAT: reg_rdata_o = {rxc, txc_q, !txb_full_q, {(DATA_W-3){1'b0}}};
      ADDR_CTRL: reg_rdata_o = {ctrl_q, {(DATA_W-CTRL_W){1'b0}}};
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_rxc_o = rxc & ctrl_q.rxc_ie;
  assign irq_txc_o = txc_q & ctrl_q.txc_ie;
  assign irq_dre_o = !txb_full_q & ctrl_q.dre_ie;

  p_refill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (!txb_full_q && sh_busy));
  p_txc_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_done && !txb_full_q) |=> txc_q);
  p_txc_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_done && txb_full_q && !txc_q) |=> !txc_q);
  p_txc_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txc_ack_i && !sh_done) |=> !txc_q);
endmodule

// File: tb/test_usart_spi_master.sv
`timescale 1ns/1ps
module test_usart_spi_master;
  localparam int H = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, re = 1'b1, ack = 1'b0, miso = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_rxc, irq_txc, irq_dre, sck, mosi;

  int tests = 0, fails = 0, rises = 0, r0 = 0;
  logic prev_sck = 1'b0;

  always #2 clk = ~clk;

  usart_spi_master #(.SCK_HALF(H), .DATA_W(8)) i_usart_spi_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .txc_ack_i(ack),
    .irq_rxc_o(irq_rxc), .irq_txc_o(irq_txc), .irq_dre_o(irq_dre),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso)
  );

  // reference model
  logic       m_full, m_busy, m_done, m_rxc, m_txc, m_samp;
  logic [7:0] m_buf, m_tx, m_rxacc, m_rxd, m_ctrl;
  int         m_el;
  logic       o_full, o_busy, o_done, ld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_done = 0; m_rxc = 0; m_txc = 0; m_samp = 0;
      m_buf = 0; m_tx = 0; m_rxacc = 0; m_rxd = 0; m_ctrl = 0; m_el = 0;
    end else begin
      o_full = m_full; o_busy = m_busy; o_done = m_done;
      ld = o_full && !o_busy;
      if (!m_ctrl[4]) begin m_rxc = 0; m_rxd = 0; end
      else if (o_done) begin m_rxc = 1; m_rxd = m_rxacc; end
      else if (re && addr == 2'd0) m_rxc = 0;
      if (o_done && !o_full) m_txc = 1;
      else if (ack || (we && addr == 2'd1 && wdata[6])) m_txc = 0;
      m_done = 0;
      if (o_busy) begin
        if ((m_el + 1) % H == 0) begin
          if (((m_el / H) % 2) == 0) m_samp = miso;
          else m_rxacc = {m_rxacc[6:0], m_samp};
        end
        if (m_el + 1 == 16 * H) begin m_busy = 0; m_done = 1; end
        m_el = m_el + 1;
      end else if (ld) begin
        m_busy = 1; m_el = 0; m_tx = m_buf;
      end
      if (ld) m_full = 0;
      else if (we && addr == 2'd0 && m_ctrl[3] && !o_full) begin m_full = 1; m_buf = wdata; end
      if (we && addr == 2'd2) m_ctrl = {wdata[7:3], 3'b000};
    end
  end

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_rxd;
      2'd1: return {m_rxc, m_txc, !m_full, 5'b00000};
      2'd2: return m_ctrl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk({7'd0, sck}, {7'd0, m_busy && ((m_el / H) % 2 == 1)}, "R3 sck");
      chk({7'd0, mosi}, {7'd0, m_busy ? m_tx[7 - m_el / (2 * H)] : 1'b0}, "R3 mosi");
      chk({7'd0, irq_rxc}, {7'd0, m_ctrl[7] & m_rxc}, "R11 irq_rxc");
      chk({7'd0, irq_txc}, {7'd0, m_ctrl[6] & m_txc}, "R11 irq_txc");
      chk({7'd0, irq_dre}, {7'd0, m_ctrl[5] & !m_full}, "R11 irq_dre");
      case (addr)
        2'd0:    chk(rdata, m_read(addr), "R4 data read");
        2'd1:    chk(rdata, m_read(addr), "R9 status read");
        default: chk(rdata, m_read(addr), "R10 ctrl read");
      endcase
      if (sck && !prev_sck) rises++;
      prev_sck = sck;
    end
  end

  always @(negedge clk) miso <= 1'($urandom_range(1, 0));

  task automatic defaults();
    we = 0; re = 1; addr = 2'd1; ack = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    defaults();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1; re = 0; addr = a; wdata = d; ack = 0;
    @(negedge clk);
    defaults();
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    we = 0; re = 1; addr = 2'd1; ack = 1;
    @(negedge clk);
    defaults();
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [7:0] mask,
                           input logic [7:0] exp, input string tag);
    @(negedge clk);
    we = 0; re = 1; addr = a; ack = 0;
    #1;
    chk(rdata & mask, exp, tag);
    @(negedge clk);
    defaults();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_expect(2'd1, 8'hFF, 8'h20, "R1 status after reset");
    chk({6'd0, sck, mosi}, 8'h00, "R1 serial idle");
    chk({5'd0, irq_rxc, irq_txc, irq_dre}, 8'h00, "R1 irqs low");
    // R10 control readback, reserved bits
    wr(2'd2, 8'hFF);
    rd_expect(2'd2, 8'hFF, 8'hF8, "R10 ctrl reserved");
    // single frame
    r0 = rises;
    wr(2'd0, 8'hA5);
    idle(40);
    chk(8'(rises - r0), 8'd8, "R2 one frame");
    rd_expect(2'd1, 8'hE0, 8'hE0, "R7 flags after frame");
    rd_expect(2'd0, 8'h00, 8'h00, "R5 data read");
    rd_expect(2'd1, 8'h80, 8'h00, "R5 rxc cleared");
    // R8 clear rules
    wr(2'd1, 8'h00);
    rd_expect(2'd1, 8'h40, 8'h40, "R8 write zero keeps");
    wr(2'd1, 8'hFF);
    rd_expect(2'd1, 8'h40, 8'h00, "R8 write one clears");
    rd_expect(2'd1, 8'h1F, 8'h00, "R10 status reserved");
    // back-to-back, third write ignored
    r0 = rises;
    wr(2'd0, 8'h3C);
    idle(4);
    wr(2'd0, 8'hC3);
    wr(2'd0, 8'h99);
    rd_expect(2'd1, 8'h60, 8'h00, "R9 buffer full");
    idle(80);
    chk(8'(rises - r0), 8'd16, "R2 full write ignored");
    rd_expect(2'd1, 8'h40, 8'h40, "R7 set after drain");
    ack_pulse();
    rd_expect(2'd1, 8'h40, 8'h00, "R8 ack clears");
    // R12 disable transmitter with queued byte
    r0 = rises;
    wr(2'd0, 8'h5A);
    idle(2);
    wr(2'd0, 8'h81);
    wr(2'd2, 8'hF0);
    idle(40);
    wr(2'd0, 8'h77);
    idle(60);
    chk(8'(rises - r0), 8'd16, "R12 queued frames finish");
    rd_expect(2'd1, 8'h60, 8'h60, "R12 txc and dre");
    rd_expect(2'd1, 8'h80, 8'h80, "R4 rxc set");
    // R6 receiver flush
    wr(2'd2, 8'hE0);
    rd_expect(2'd1, 8'h80, 8'h00, "R6 rxc flushed");
    rd_expect(2'd0, 8'hFF, 8'h00, "R6 data flushed");
    wr(2'd2, 8'hE8);
    wr(2'd0, 8'h12);
    idle(40);
    rd_expect(2'd1, 8'hC0, 8'h40, "R6 no store while off");
    rd_expect(2'd3, 8'hFF, 8'h00, "R10 unused address");
    idle(4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule